// File: doc/BRIEF.md
# Watchdog Timer with Restart Register

This block is a watchdog peripheral on a simple byte-wide address/write/read bus. Its core is a down counter that is loaded with its all-ones top value (7FFFh with the default 15-bit width). A clock prescaler drives the counter, and it is set to divide the input clock by either 16 or 128. Firmware keeps the system alive by writing to the start register. The written data is irrelevant: any such write reloads the counter, clears the prescaler and starts the counting if it was stopped. When the counter steps past zero, the block emits a single-cycle timeout pulse. The counter then reloads and keeps running, so firmware is expected to restart it after the timeout has been serviced.

The control register holds the prescaler select bit and a sticky warm-start flag. The flag reads 0 after power-on. Any write to the control register sets it, and only the power-on reset clears it, so firmware can use it to tell a cold boot from a later system reset. The low five bits of the control register are read-only and show the counter's most significant bits. The block has two reset inputs. Power-on reset clears everything. System reset clears the prescaler, the select bit and the counter but keeps the warm-start flag. After either reset the counter holds its top value and does not count until the first start write.

Top module: `wdog_unit`

## Requirements
- R1: After reset, a read of the control register (address 0Fh) returns 1Fh, and wdt_timeout is low.
- R2: A write to the start register (address 0Eh) loads the counter to all ones, clears the prescaler and starts counting, whatever the write data is. Reads of 0Eh, and of any address other than 0Fh, return 00h.
- R3: Control bit 7 selects the prescaler. With 0 the counter decrements once every 16 clocks, and with 1 once every 128 clocks, counted from the start write.
- R4: When the counter is at zero and a prescaler tick arrives, wdt_timeout is high for exactly one cycle, and the counter reloads to all ones and keeps counting. Measured from the clock edge that takes the start write, the first pulse follows after div × 2^CNT_W clocks (div is 16 or 128), and each later pulse follows the one before by the same interval.
- R5: Control bits 4..0 read back the five most significant counter bits, live.
- R6: Control bit 5 is the warm-start flag. It is 0 after power-on reset and set by any write to the control register, whatever the data. Writing 0 to it does not clear it.
- R7: Control bit 6 is reserved and always reads 0. Writing 1 to it has no effect. Writes to bits 4..0 have no effect.
- R8: System reset (rst_n low) clears bit 7, stops the counter and reloads it to all ones, and leaves the warm-start flag unchanged. Power-on reset (por_n low) also clears the flag.
- R9: A start write while the counter is running restarts the full timeout interval from that write.
- R10: After reset the counter does not move, and no timeout occurs, until the first start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| wdt_timeout | output | 1 | One-cycle pulse on counter underflow |

## Verification
The counter is run with the fast divider and with the slow divider. Each run measures the clock count from the start write to the first timeout pulse, and for the fast divider also to the second pulse, and reads the live high-order bits at chosen points of the run. These measurements separate a wrong division ratio, an off-by-one in the underflow and a missing reload. A restart is issued halfway through a run with nonzero data, and the bench checks that the full interval is measured again from the second write and that the data has no effect. Sequences of control writes and the two resets separate the flag's sticky behaviour from the clearing of the select bit by either reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HI_BITS = 5;

  // Tick when the low `log2` bits of the free-running prescaler are all ones.
  function automatic logic div_tick(input logic [6:0] pre, input logic slow,
                                    input int unsigned fast_log2, input int unsigned slow_log2);
    logic fast_hit;
    logic slow_hit;
    fast_hit = 1'b1;
    slow_hit = 1'b1;
    for (int i = 0; i < 7; i++) begin
      if (i < fast_log2) fast_hit = fast_hit & pre[i];
      if (i < slow_log2) slow_hit = slow_hit & pre[i];
    end
    return slow ? slow_hit : fast_hit;
  endfunction

  // Control register layout: {select, reserved 0, warm flag, counter high bits}.
  function automatic logic [BYTE_W-1:0] pack_ctrl(input logic sel, input logic warm,
                                                  input logic [HI_BITS-1:0] hi);
    return {sel, 1'b0, warm, hi};
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned FAST_LOG2 = 4,
  parameter int unsigned SLOW_LOG2 = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int unsigned PRE_W = SLOW_LOG2;

  logic [PRE_W-1:0] pre_q;
  logic [6:0]       pre_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (clr)  pre_q <= '0;
    else if (run)  pre_q <= pre_q + 1'b1;
  end

  assign pre_ext = 7'(pre_q);
  assign tick    = run & !clr & wdog_pkg::div_tick(pre_ext, slow, FAST_LOG2, SLOW_LOG2);
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic at_zero;
  assign at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= TOP;
      running   <= 1'b0;
      underflow <= 1'b0;
    end else if (load) begin
      count     <= TOP;
      running   <= 1'b1;
      underflow <= 1'b0;
    end else if (running && tick) begin
      count     <= at_zero ? TOP : count - 1'b1;
      underflow <= at_zero;
    end else begin
      underflow <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int unsigned          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR  = 'h0F,
  parameter logic [ADDR_W-1:0]    START_ADDR = 'h0E
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic [4:0]        cnt_hi,
  output logic [7:0]        rdata,
  output logic              slow_sel,
  output logic              warm,
  output logic              ctrl_wr,
  output logic              start_wr
);
  logic hit_ctrl;
  logic unused_wdata;

  assign hit_ctrl     = (addr == CTRL_ADDR);
  assign ctrl_wr      = wr & hit_ctrl;
  assign start_wr     = wr & (addr == START_ADDR);
  assign unused_wdata = ^wdata[6:0];

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)   slow_sel <= 1'b0;
    else if (ctrl_wr) slow_sel <= wdata[7];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       warm <= 1'b0;
    else if (ctrl_wr) warm <= 1'b1;
  end

  assign rdata = hit_ctrl ? wdog_pkg::pack_ctrl(slow_sel, warm, cnt_hi) : 8'h00;
endmodule

// File: rtl/wdog_unit.sv
module wdog_unit #(
  parameter int unsigned       CNT_W      = 15,
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h0F,
  parameter logic [ADDR_W-1:0] START_ADDR = 'h0E,
  parameter int unsigned       FAST_LOG2  = 4,
  parameter int unsigned       SLOW_LOG2  = 7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wdt_timeout
);
  localparam int unsigned HI = wdog_pkg::HI_BITS;

  logic             sys_rst_n;
  logic             start_wr;
  logic             ctrl_wr;
  logic             slow_sel;
  logic             warm_flag;
  logic             pre_tick;
  logic             running;
  logic [CNT_W-1:0] count_q;

  assign sys_rst_n = por_n & rst_n;

  wdog_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .START_ADDR(START_ADDR)
  ) u_regs (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .cnt_hi(count_q[CNT_W-1 -: HI]), .rdata(bus_rdata),
    .slow_sel(slow_sel), .warm(warm_flag), .ctrl_wr(ctrl_wr), .start_wr(start_wr)
  );

  wdog_prescale #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_pre (
    .clk(clk), .rst_n(sys_rst_n), .clr(start_wr), .run(running),
    .slow(slow_sel), .tick(pre_tick)
  );

  wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(sys_rst_n), .load(start_wr), .tick(pre_tick),
    .count(count_q), .running(running), .underflow(wdt_timeout)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned CNT_W = 15
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             start_wr,
  input logic             ctrl_wr,
  input logic             warm_flag,
  input logic             pre_tick,
  input logic             running,
  input logic [CNT_W-1:0] count_q,
  input logic             wdt_timeout
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_start_reload_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    start_wr |=> (running && count_q == TOP && !wdt_timeout));

  p_tick_isolated_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    pre_tick |=> !pre_tick);

  p_decrement_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (pre_tick && !start_wr && count_q != '0) |=> (count_q == CNT_W'($past(count_q) - 1'b1)));

  p_underflow_reload_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (pre_tick && !start_wr && count_q == '0) |=> (wdt_timeout && count_q == TOP));

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wdt_timeout |=> !wdt_timeout);

  p_ctrl_sets_warm_r6: assert property (@(posedge clk) disable iff (!por_n)
    ctrl_wr |=> warm_flag);

  p_warm_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    warm_flag |=> warm_flag);

  p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!running && !start_wr) |=> ($stable(count_q) && !wdt_timeout));
endmodule

bind wdog_unit wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .start_wr(start_wr),
  .ctrl_wr(ctrl_wr), .warm_flag(warm_flag), .pre_tick(pre_tick),
  .running(running), .count_q(count_q), .wdt_timeout(wdt_timeout)
);

// File: tb/wdog_unit_bench.sv
module wdog_unit_bench;
  localparam int unsigned CW   = 9;
  localparam int unsigned TOPV = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wdt_timeout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdog_unit #(.CNT_W(CW)) u_wdog_unit (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_timeout(wdt_timeout)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // high five bits expected n clocks after the start write edge
  function automatic int exp_hi(input int n, input int div);
    return ((TOPV - (n / div)) >> (CW - 5)) & 32'h1F;
  endfunction

  // counts clocks from the current negedge until a timeout pulse, limit lim
  task automatic wait_timeout(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_timeout) begin n = i; break; end
    end
  endtask

  task automatic pulse_reset(input bit por);
    @(negedge clk);
    if (por) por_n = 1'b0; else rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    bus_read(8'h0F, d);
    check("R1", "ctrl after reset", d, 8'h1F);
    check("R1", "timeout after reset", wdt_timeout, 0);
  endtask

  task automatic t_stopped();
    logic [7:0] d;
    int seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wdt_timeout) seen++;
    end
    bus_read(8'h0F, d);
    check("R10", "hi bits before start", d[4:0], 5'h1F);
    check("R10", "no timeout before start", seen, 0);
  endtask

  task automatic t_read_zero();
    logic [7:0] d;
    bus_read(8'h0E, d);
    check("R2", "start reg read", d, 0);
    bus_read(8'h33, d);
    check("R2", "unmapped read", d, 0);
  endtask

  task automatic t_fast_run();
    logic [7:0] d;
    int n;
    int first = -1;
    int second = -1;
    bus_write(8'h0E, 8'h00);
    for (int i = 1; i <= 16 * (TOPV + 1); i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 512 || i == 4096) begin
        bus_read(8'h0F, d);
        check("R5", $sformatf("hi bits at %0d", i), d[4:0], exp_hi(i, 16));
      end
      if (i == 512) begin
        bus_read(8'h0F, d);
        check("R3", "fast decrement rate", d[4:0], 5'h1D);
      end
      if (wdt_timeout && first < 0) first = i;
    end
    check("R4", "first timeout clocks /16", first, 16 * (TOPV + 1));
    @(posedge clk); @(negedge clk);
    check("R4", "pulse one cycle", wdt_timeout, 0);
    bus_read(8'h0F, d);
    check("R4", "reload after underflow", d[4:0], 5'h1F);
    wait_timeout(16 * (TOPV + 1) + 4, n);
    second = n + 1;
    check("R4", "second timeout interval", second, 16 * (TOPV + 1));
  endtask

  task automatic t_restart();
    logic [7:0] d;
    int n;
    int seen = 0;
    bus_write(8'h0E, 8'h00);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (wdt_timeout) seen++;
    end
    bus_write(8'h0E, 8'hA5);
    bus_read(8'h0F, d);
    check("R9", "hi bits after restart", d[4:0], 5'h1F);
    check("R2", "data ignored: slow bit unchanged", d[7], 0);
    wait_timeout(16 * (TOPV + 1) + 4, n);
    check("R9", "timeout measured from restart", n, 16 * (TOPV + 1));
    check("R9", "no timeout before restart", seen, 0);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] d;
    bus_write(8'h0F, 8'h5F);
    bus_read(8'h0F, d);
    check("R6", "warm set by write", d[5], 1);
    check("R7", "reserved reads 0", d[6], 0);
    check("R7", "low bits not written", d[7:0] & 8'h9F, {3'b000, 5'(exp_hi(0, 16))});
    bus_write(8'h0F, 8'h00);
    bus_read(8'h0F, d);
    check("R6", "warm not cleared by 0", d[5], 1);
  endtask

  task automatic t_slow_run();
    logic [7:0] d;
    int first = -1;
    bus_write(8'h0F, 8'h80);
    bus_write(8'h0E, 8'h00);
    for (int i = 1; i <= 128 * (TOPV + 1); i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 128 * 32) begin
        bus_read(8'h0F, d);
        check("R3", "slow decrement rate", d[4:0], exp_hi(i, 128));
        check("R3", "select reads 1", d[7], 1);
      end
      if (wdt_timeout && first < 0) first = i;
    end
    check("R4", "first timeout clocks /128", first, 128 * (TOPV + 1));
  endtask

  task automatic t_sys_reset();
    logic [7:0] d;
    int n;
    bus_write(8'h0E, 8'h00);
    repeat (1000) @(negedge clk);
    pulse_reset(1'b0);
    bus_read(8'h0F, d);
    check("R8", "sys reset ctrl", d, 8'h3F);
    wait_timeout(16 * (TOPV + 1) + 200, n);
    check("R8", "stopped after sys reset", n, -1);
    pulse_reset(1'b1);
    bus_read(8'h0F, d);
    check("R8", "por ctrl", d, 8'h1F);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_stopped();
    t_read_zero();
    t_fast_run();
    t_restart();
    t_ctrl_bits();
    t_slow_run();
    bus_write(8'h0F, 8'h00);
    t_sys_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule